// File: doc/BRIEF.md
# Instruction fetch unit with redirect

This block is the front end of a small CPU pipeline. It issues reads of consecutive instruction words on a pipelined Wishbone bus and passes each returned word, with its address, to the decode stage over a valid/ready handshake. Only one bus read is outstanding at a time. The fetch does not wait for decode to take the current word before issuing the next read. A second register holds a word that returns while decode is stalled. A read is issued only when storage is certain to be free for its answer.

Two inputs carry no back-pressure, and the block takes both in any cycle, including the same cycle. They are the bus acknowledge with its read data, and a redirect strobe with a new program counter from decode. A redirect empties both word registers and drops the bus cycle for one clock, which abandons any pending read. Fetching then restarts at the new address. After reset, fetching starts at a parameter address.

Top module: `ifetch_unit`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `wb_cyc_o`, `wb_stb_o` and `dec_valid_o` are all low.
- R2: `wb_stb_o` is never high while `wb_cyc_o` is low.
- R3: Once a request is accepted (CYC, STB high and STALL low at an edge), STB stays low until ACK arrives or CYC drops.
- R4: While a request is stalled, STB stays high and the address stays the same in the next cycle, unless a redirect is presented.
- R5: The first accepted bus address after reset is `RESET_ADDR`. The first after a redirect is the redirect address. Each later one is the last acknowledged address plus one, modulo 2^16. An ACK in a redirect cycle is discarded.
- R6: While `dec_valid_o` is high and `dec_ready_i` is low, valid, address and word hold in the next cycle, unless a redirect is presented.
- R7: Every word decode takes equals the bus data returned for its address. Taken addresses start at the restart address and rise by one (modulo 2^16) with no gaps, so no acknowledged word is lost.
- R8: With two words stored, decode can take words on two consecutive cycles.
- R9: In the cycle after a redirect, `wb_cyc_o` and `dec_valid_o` are low. A word offered in the redirect cycle is not counted as taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Bus request strobe |
| wb_stall_i | input | 1 | Bus request not yet accepted |
| wb_adr_o | output | AW | Bus word address |
| wb_ack_i | input | 1 | Read data valid |
| wb_dat_i | input | DW | Read data |
| dec_valid_o | output | 1 | Word offered to decode |
| dec_ready_i | input | 1 | Decode takes the word |
| dec_addr_o | output | AW | Address of offered word |
| dec_word_o | output | DW | Offered instruction word |
| redir_valid_i | input | 1 | New program counter strobe |
| redir_addr_i | input | AW | New program counter |

## Verification
The bench drives inputs on the falling edge. At each falling edge it first evaluates what happened at the rising edge before. It decides bus acceptance, ACK, decode take and redirect from the inputs it held and a snapshot of the outputs from before that edge. Bus address checks fall in the cycle where the request is accepted. A returned word can reach decode one edge after its ACK. Stall holds, decode holds and redirect effects (R4, R6, R9) are checked against the outputs one edge later. The bench slave acknowledges no earlier than the cycle after acceptance, with a random extra wait of up to two cycles.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;
  localparam int FETCH_AW = 16;
  localparam int FETCH_DW = 16;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_REQ  = 2'd1,
    BUS_WAIT = 2'd2
  } bus_state_t;
endpackage

// File: rtl/ifetch_bus_ctl.sv
module ifetch_bus_ctl
  import ifetch_pkg::*;
#(
  parameter int AW = FETCH_AW,
  parameter int DW = FETCH_DW,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          redir_valid,
  input  logic [AW-1:0] redir_addr,
  input  logic          room_ok,
  input  logic          bus_stall,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_dat,
  output logic          bus_cyc,
  output logic          bus_stb,
  output logic [AW-1:0] bus_adr,
  output logic          push,
  output logic [AW-1:0] push_addr,
  output logic [DW-1:0] push_data
);
  bus_state_t    state_q;
  logic          cyc_q;
  logic          stb_q;
  logic [AW-1:0] adr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BUS_IDLE;
      cyc_q   <= 1'b0;
      stb_q   <= 1'b0;
      adr_q   <= RESET_ADDR;
    end else if (redir_valid) begin
      // abandon whatever is in flight, restart after one idle cycle
      state_q <= BUS_IDLE;
      cyc_q   <= 1'b0;
      stb_q   <= 1'b0;
      adr_q   <= redir_addr;
    end else begin
      unique case (state_q)
        BUS_IDLE: begin
          if (room_ok) begin
            state_q <= BUS_REQ;
            cyc_q   <= 1'b1;
            stb_q   <= 1'b1;
          end
        end
        BUS_REQ: begin
          if (!bus_stall) begin
            state_q <= BUS_WAIT;
            stb_q   <= 1'b0;
          end
        end
        BUS_WAIT: begin
          if (bus_ack) begin
            adr_q <= adr_q + 1'b1;
            if (room_ok) begin
              state_q <= BUS_REQ;
              stb_q   <= 1'b1;
            end else begin
              state_q <= BUS_IDLE;
              cyc_q   <= 1'b0;
            end
          end
        end
        default: begin
          state_q <= BUS_IDLE;
          cyc_q   <= 1'b0;
          stb_q   <= 1'b0;
        end
      endcase
    end
  end

  assign bus_cyc   = cyc_q;
  assign bus_stb   = stb_q;
  assign bus_adr   = adr_q;
  assign push      = (state_q == BUS_WAIT) && bus_ack && !redir_valid;
  assign push_addr = adr_q;
  assign push_data = bus_dat;
endmodule

// File: rtl/ifetch_word_buf.sv
module ifetch_word_buf
  import ifetch_pkg::*;
#(
  parameter int AW = FETCH_AW,
  parameter int DW = FETCH_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          take,
  output logic          head_valid,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          room_ok
);
  localparam int SLOTS = 2;

  logic          head_v, spare_v;
  logic [AW-1:0] head_a, spare_a;
  logic [DW-1:0] head_d, spare_d;
  logic          pop;
  logic [2:0]    occ_nxt;

  assign pop     = head_v && take;
  assign occ_nxt = {2'b00, head_v} + {2'b00, spare_v} + {2'b00, push} - {2'b00, pop};
  assign room_ok = flush || (occ_nxt < 3'(SLOTS));

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head_v  <= 1'b0;
      spare_v <= 1'b0;
    end else if (pop) begin
      if (spare_v) begin
        head_v  <= 1'b1;
        head_a  <= spare_a;
        head_d  <= spare_d;
        spare_v <= push;
        if (push) begin
          spare_a <= push_addr;
          spare_d <= push_data;
        end
      end else begin
        head_v <= push;
        if (push) begin
          head_a <= push_addr;
          head_d <= push_data;
        end
      end
    end else if (!head_v) begin
      head_v <= push;
      if (push) begin
        head_a <= push_addr;
        head_d <= push_data;
      end
    end else if (push) begin
      spare_v <= 1'b1;
      spare_a <= push_addr;
      spare_d <= push_data;
    end
  end

  assign head_valid = head_v;
  assign head_addr  = head_a;
  assign head_data  = head_d;
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit
  import ifetch_pkg::*;
#(
  parameter int AW = FETCH_AW,
  parameter int DW = FETCH_DW,
  parameter logic [AW-1:0] RESET_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst,
  output logic          wb_cyc_o,
  output logic          wb_stb_o,
  input  logic          wb_stall_i,
  output logic [AW-1:0] wb_adr_o,
  input  logic          wb_ack_i,
  input  logic [DW-1:0] wb_dat_i,
  output logic          dec_valid_o,
  input  logic          dec_ready_i,
  output logic [AW-1:0] dec_addr_o,
  output logic [DW-1:0] dec_word_o,
  input  logic          redir_valid_i,
  input  logic [AW-1:0] redir_addr_i
);
  logic          room_ok;
  logic          push;
  logic [AW-1:0] push_addr;
  logic [DW-1:0] push_data;

  ifetch_bus_ctl #(.AW(AW), .DW(DW), .RESET_ADDR(RESET_ADDR)) u_bus (
    .clk        (clk),
    .rst        (rst),
    .redir_valid(redir_valid_i),
    .redir_addr (redir_addr_i),
    .room_ok    (room_ok),
    .bus_stall  (wb_stall_i),
    .bus_ack    (wb_ack_i),
    .bus_dat    (wb_dat_i),
    .bus_cyc    (wb_cyc_o),
    .bus_stb    (wb_stb_o),
    .bus_adr    (wb_adr_o),
    .push       (push),
    .push_addr  (push_addr),
    .push_data  (push_data)
  );

  ifetch_word_buf #(.AW(AW), .DW(DW)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .flush     (redir_valid_i),
    .push      (push),
    .push_addr (push_addr),
    .push_data (push_data),
    .take      (dec_ready_i),
    .head_valid(dec_valid_o),
    .head_addr (dec_addr_o),
    .head_data (dec_word_o),
    .room_ok   (room_ok)
  );
endmodule

// File: rtl/ifetch_unit_chk.sv
module ifetch_unit_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wb_cyc_o,
  input logic          wb_stb_o,
  input logic          wb_stall_i,
  input logic [AW-1:0] wb_adr_o,
  input logic          wb_ack_i,
  input logic          dec_valid_o,
  input logic          dec_ready_i,
  input logic [AW-1:0] dec_addr_o,
  input logic [DW-1:0] dec_word_o,
  input logic          redir_valid_i
);
  logic          in_flight;
  logic          last_v;
  logic [AW-1:0] last_a;

  always_ff @(posedge clk) begin
    if (rst || !wb_cyc_o || wb_ack_i) in_flight <= 1'b0;
    else if (wb_stb_o && !wb_stall_i) in_flight <= 1'b1;

    if (rst || redir_valid_i) last_v <= 1'b0;
    else if (dec_valid_o && dec_ready_i) begin
      last_v <= 1'b1;
      last_a <= dec_addr_o;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!wb_cyc_o && !wb_stb_o && !dec_valid_o));

  assert_stb_in_cyc_R2: assert property (@(posedge clk) disable iff (rst)
    wb_stb_o |-> wb_cyc_o);

  assert_single_outstanding_R3: assert property (@(posedge clk) disable iff (rst)
    in_flight |-> !wb_stb_o);

  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (wb_stb_o && wb_stall_i && !redir_valid_i) |=> (wb_stb_o && $stable(wb_adr_o)));

  assert_decode_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_o && !dec_ready_i && !redir_valid_i) |=>
      (dec_valid_o && $stable(dec_addr_o) && $stable(dec_word_o)));

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
    (dec_valid_o && dec_ready_i && !redir_valid_i && last_v) |->
      (dec_addr_o == AW'(last_a + 1'b1)));

  assert_redirect_flush_R9: assert property (@(posedge clk) disable iff (rst)
    redir_valid_i |=> (!wb_cyc_o && !dec_valid_o));
endmodule

bind ifetch_unit ifetch_unit_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .wb_cyc_o     (wb_cyc_o),
  .wb_stb_o     (wb_stb_o),
  .wb_stall_i   (wb_stall_i),
  .wb_adr_o     (wb_adr_o),
  .wb_ack_i     (wb_ack_i),
  .dec_valid_o  (dec_valid_o),
  .dec_ready_i  (dec_ready_i),
  .dec_addr_o   (dec_addr_o),
  .dec_word_o   (dec_word_o),
  .redir_valid_i(redir_valid_i)
);

// File: tb/ifetch_unit_test.sv
module ifetch_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [AW-1:0] RST_PC = 16'h0100;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wb_cyc_o, wb_stb_o, wb_stall_i, wb_ack_i;
  logic [AW-1:0] wb_adr_o;
  logic [DW-1:0] wb_dat_i;
  logic          dec_valid_o, dec_ready_i;
  logic [AW-1:0] dec_addr_o;
  logic [DW-1:0] dec_word_o;
  logic          redir_valid_i;
  logic [AW-1:0] redir_addr_i;

  ifetch_unit #(.AW(AW), .DW(DW), .RESET_ADDR(RST_PC)) uut (
    .clk(clk), .rst(rst),
    .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_stall_i(wb_stall_i),
    .wb_adr_o(wb_adr_o), .wb_ack_i(wb_ack_i), .wb_dat_i(wb_dat_i),
    .dec_valid_o(dec_valid_o), .dec_ready_i(dec_ready_i),
    .dec_addr_o(dec_addr_o), .dec_word_o(dec_word_o),
    .redir_valid_i(redir_valid_i), .redir_addr_i(redir_addr_i)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // bench slave and scoreboard state
  bit            pend;
  logic [AW-1:0] pend_addr;
  int            wait_left;
  logic [AW-1:0] exp_bus, exp_dec;
  bit            snap_cyc, snap_stb, snap_dv;
  logic [AW-1:0] snap_adr, snap_da;
  logic [DW-1:0] snap_dw;
  bit            took;
  int            takes;
  bit            force_redir;
  logic [AW-1:0] force_addr;

  function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic snap();
    snap_cyc = wb_cyc_o; snap_stb = wb_stb_o; snap_adr = wb_adr_o;
    snap_dv  = dec_valid_o; snap_da = dec_addr_o; snap_dw = dec_word_o;
  endtask

  task automatic restart();
    pend = 0; wait_left = 0;
    exp_bus = RST_PC; exp_dec = RST_PC;
    wb_stall_i = 0; wb_ack_i = 0; wb_dat_i = '0;
    dec_ready_i = 0; redir_valid_i = 0; redir_addr_i = '0;
    rst = 1;
    repeat (3) @(negedge clk);
    chk(!wb_cyc_o && !wb_stb_o && !dec_valid_o, "R1", "outputs in reset",
        {wb_cyc_o, wb_stb_o, dec_valid_o}, 0);
    rst = 0;
    snap();
  endtask

  // one clock: judge the edge just passed, then drive the next one
  task automatic step(input int redir_pct, input int ready_pct, input int stall_pct);
    bit acc;
    @(negedge clk);
    took = 0;
    acc = snap_cyc && snap_stb && !wb_stall_i;
    if (snap_stb) chk(snap_cyc, "R2", "stb without cyc", snap_cyc, 1);
    if (pend) chk(!snap_stb, "R3", "stb while outstanding", snap_stb, 0);
    if (acc) chk(snap_adr == exp_bus, "R5", "bus address", snap_adr, exp_bus);
    if (wb_ack_i && pend) begin
      if (!redir_valid_i) exp_bus = pend_addr + 1'b1;
      pend = 0;
    end
    if (acc) begin
      pend = 1; pend_addr = snap_adr; wait_left = $urandom % 3;
    end
    if (snap_dv && dec_ready_i && !redir_valid_i) begin
      chk(snap_dw == memf(snap_da), "R7", "decode word", snap_dw, memf(snap_da));
      chk(snap_da == exp_dec, "R7", "decode address", snap_da, exp_dec);
      exp_dec = snap_da + 1'b1;
      took = 1; takes++;
    end
    if (snap_stb && wb_stall_i && !redir_valid_i)
      chk(wb_stb_o && wb_adr_o == snap_adr, "R4", "stalled request held",
          wb_adr_o, snap_adr);
    if (snap_dv && !dec_ready_i && !redir_valid_i)
      chk(dec_valid_o && dec_addr_o == snap_da && dec_word_o == snap_dw,
          "R6", "decode output held", dec_addr_o, snap_da);
    if (redir_valid_i) begin
      chk(!wb_cyc_o && !dec_valid_o, "R9", "flush after redirect",
          {wb_cyc_o, dec_valid_o}, 0);
      exp_bus = redir_addr_i; exp_dec = redir_addr_i;
    end
    // drive next cycle
    if (!wb_cyc_o) pend = 0;
    if (pend && wait_left == 0) begin
      wb_ack_i = 1; wb_dat_i = memf(pend_addr);
    end else begin
      wb_ack_i = 0; wb_dat_i = DW'($urandom);
      if (pend) wait_left--;
    end
    wb_stall_i = (int'($urandom % 100) < stall_pct);
    if (force_redir) begin
      redir_valid_i = 1; redir_addr_i = force_addr; force_redir = 0;
    end else begin
      redir_valid_i = (int'($urandom % 100) < redir_pct);
      redir_addr_i = ($urandom % 4 == 0) ? AW'(16'hFFFC + ($urandom % 4)) : AW'($urandom);
    end
    dec_ready_i = (int'($urandom % 100) < ready_pct);
    snap();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0;
    void'($urandom(32'd1234));
    force_redir = 0; takes = 0;
    restart();                                       // R1 at reset
    for (int i = 0; i < 3000; i++) step(3, 60, 40);  // mixed random traffic

    // directed: redirect just below the address wrap
    force_redir = 1; force_addr = 16'hFFFE;
    for (int i = 0; i < 200; i++) step(0, 70, 30);

    // R8: fill both slots with decode stalled, then take on two cycles in a row
    for (int i = 0; i < 30; i++) step(0, 0, 20);
    chk(dec_valid_o, "R8", "word waiting", dec_valid_o, 1);
    t0 = takes;
    step(0, 100, 0);   // drive ready high
    step(0, 100, 0);   // first take judged here
    chk(took && dec_valid_o, "R8", "second word after first take",
        {took, dec_valid_o}, 3);
    step(0, 0, 0);     // second take judged here
    chk(took && takes == t0 + 2, "R8", "back-to-back takes", takes - t0, 2);

    // redirects on consecutive cycles
    force_redir = 1; force_addr = 16'h2000;
    step(0, 50, 0);
    force_redir = 1; force_addr = 16'h3000;
    step(0, 50, 0);
    for (int i = 0; i < 200; i++) step(0, 100, 0);

    // heavy redirect pressure, then full throughput
    for (int i = 0; i < 1500; i++) step(15, 80, 30);
    for (int i = 0; i < 500; i++) step(0, 100, 0);

    // reset mid-run restarts at the reset address
    restart();
    for (int i = 0; i < 1000; i++) step(5, 50, 50);
    chk(takes > 1000, "R7", "words delivered overall", takes, 1000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule